// File: doc/BRIEF.md
# Sprite attribute memory DMA engine

This block fills the 160-byte sprite attribute RAM from system memory without CPU help. The CPU writes a page number, and the engine takes the page number times 256 as its source base. It then reads source bytes one after another through a read-only master port and writes each byte into the attribute RAM at the matching offset. The start latency is fixed and so is the spacing between bytes, so software can tell exactly when the table is complete.

While a copy runs, the engine also sits between the CPU and the system bus. Only the high RAM window stays usable. Any other CPU read returns all ones, and any other CPU write is dropped before it reaches the bus. When the last byte has been written, the gate opens again. A page write that arrives mid-copy starts the copy over from the new page. A page above the allowed limit is ignored.

Top module: `oam_dma_engine`

## Requirements
- R1: A trigger sets the source base to `{trig_page, 8'h00}`. A trigger whose page is greater than 0xF1 is ignored: busy stays as it was and no attribute write follows. Page 0xF1 itself is accepted.
- R2: An accepted trigger writes exactly 160 bytes. For i = 0..159, the byte read from base+i goes to attribute offset i, in ascending order.
- R3: Take the clock edge that samples the trigger as edge 0. The first attribute write commits at edge 8, so `oam_we` is high in the cycle that starts at edge 7. Each later write commits 4 edges after the one before it.
- R4: `busy` rises at the trigger edge and stays high until the edge that commits offset 159. It is low from that edge on.
- R5: While `busy` is high, a CPU read of any address below 0xFF80, or of 0xFFFF, returns 0xFF on `cpu_rdata`.
- R6: While `busy` is high, a CPU write to any address below 0xFF80, or to 0xFFFF, is discarded: `bus_wr` stays low.
- R7: While `busy` is high, CPU accesses to 0xFF80..0xFFFE pass through unchanged: `bus_wr` follows `cpu_wr` and `cpu_rdata` follows `bus_rdata`.
- R8: While `busy` is low, all CPU accesses pass through unchanged.
- R9: An accepted trigger while busy restarts the copy from the new base, at offset 0, with the R3 timing. If the trigger falls in a byte-move cycle, that byte from the old copy is not written.
- R10: An ignored trigger (page above 0xF1) while busy does not change the copy in progress: its data, its count and its end time stay the same.
- R11: After reset, `busy` and `oam_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | CPU wrote a page number this cycle |
| trig_page | input | 8 | Source page number (high address byte) |
| busy | output | 1 | Copy in progress |
| mem_rd_addr | output | 16 | Source read address |
| mem_rd_data | input | 8 | Source read data (combinational) |
| oam_we | output | 1 | Attribute RAM write enable |
| oam_addr | output | 8 | Attribute RAM offset |
| oam_wdata | output | 8 | Attribute RAM write data |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bus_addr | output | 16 | Address forwarded to the system bus |
| bus_wr | output | 1 | Gated write strobe to the system bus |
| bus_wdata | output | 8 | Write data to the system bus |
| bus_rdata | input | 8 | Read data from the system bus |

## Verification
A new trigger and a byte move can land in the same cycle. The bench starts a copy, waits for the exact cycle in which the sixth byte would move, and raises a trigger for a different page in that cycle. The check passes when `oam_we` is low in that cycle, exactly five old bytes plus 160 new bytes are written in total, and every offset ends up holding data from the new page. The copy must also end exactly 644 edges after the restart.

// File: rtl/oam_dma_engine.sv
`timescale 1ns/1ps
module oam_dma_engine #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int XFER_LEN  = 160,
  parameter int FIRST_LAT = 8,
  parameter int BYTE_GAP  = 4,
  parameter logic [DATA_W-1:0] MAX_PAGE = 8'hF1,
  parameter logic [ADDR_W-1:0] HRAM_LO  = 16'hFF80,
  parameter logic [ADDR_W-1:0] HRAM_HI  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [DATA_W-1:0] trig_page,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              oam_we,
  output logic [$clog2(XFER_LEN)-1:0] oam_addr,
  output logic [DATA_W-1:0] oam_wdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int IDX_W = $clog2(XFER_LEN);
  localparam int CNT_W = $clog2(FIRST_LAT + BYTE_GAP);
  localparam int LOW_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  wait_q;
  logic              start, step, last, in_hram, blocked;

  assign start = trig_valid && (trig_page <= MAX_PAGE);
  assign step  = busy && (wait_q == '0) && !start;
  assign last  = step && (idx_q == IDX_W'(XFER_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      page_q <= '0;
      idx_q  <= '0;
      wait_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      page_q <= trig_page;
      idx_q  <= '0;
      wait_q <= CNT_W'(FIRST_LAT - 1);
    end else if (step) begin
      if (last) busy <= 1'b0;
      else      idx_q <= idx_q + 1'b1;
      wait_q <= CNT_W'(BYTE_GAP - 1);
    end else if (busy) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign mem_rd_addr = {page_q, {LOW_W{1'b0}}} + ADDR_W'(idx_q);
  assign oam_we      = step;
  assign oam_addr    = idx_q;
  assign oam_wdata   = mem_rd_data;

  assign in_hram   = (cpu_addr >= HRAM_LO) && (cpu_addr <= HRAM_HI);
  assign blocked   = busy && !in_hram;
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign bus_wr    = cpu_wr && !blocked;
  assign cpu_rdata = blocked ? '1 : bus_rdata;
endmodule

// File: rtl/oam_dma_checker.sv
`timescale 1ns/1ps
module oam_dma_checker #(
  parameter int XFER_LEN = 160,
  parameter logic [7:0] MAX_PAGE = 8'hF1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        trig_valid,
  input logic [7:0]  trig_page,
  input logic        busy,
  input logic        oam_we,
  input logic [$clog2(XFER_LEN)-1:0] oam_addr,
  input logic [15:0] mem_rd_addr,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata
);
  localparam int IDX_W = $clog2(XFER_LEN);

  // R1
  ignore_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig_valid && trig_page > MAX_PAGE) |=> !busy);
  // R2
  src_dst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> (mem_rd_addr[IDX_W-1:0] == oam_addr));
  // R3
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |=> !oam_we);
  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(oam_we) && $past(oam_addr) == IDX_W'(XFER_LEN - 1)));
  // R5
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cpu_addr < 16'hFF80 || cpu_addr == 16'hFFFF)) |-> cpu_rdata == 8'hFF);
  // R6
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cpu_addr < 16'hFF80 || cpu_addr == 16'hFFFF)) |-> !bus_wr);
  // R7
  hram_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hFF80 && cpu_addr <= 16'hFFFE) |-> (bus_wr == cpu_wr && cpu_rdata == bus_rdata));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_page <= MAX_PAGE) |-> !oam_we);
  // R11
  we_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> busy);
endmodule

bind oam_dma_engine oam_dma_checker #(.XFER_LEN(XFER_LEN), .MAX_PAGE(MAX_PAGE)) u_chk (.*);

// File: tb/tb_oam_dma_engine.sv
`timescale 1ns/1ps
module tb_oam_dma_engine;
  logic        clk = 0, rst_n = 0;
  logic        trig_valid = 0;
  logic [7:0]  trig_page = 0;
  logic        busy, oam_we, bus_wr;
  logic [15:0] mem_rd_addr, cpu_addr = 0, bus_addr;
  logic [7:0]  mem_rd_data, oam_addr, oam_wdata, cpu_rdata, bus_wdata, bus_rdata;
  logic        cpu_wr = 0;
  logic [7:0]  cpu_wdata = 8'h3C;

  oam_dma_engine dut (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return (a[15:8] * 8'd3) ^ a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] bus_byte(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'hC3;
  endfunction
  assign mem_rd_data = src_byte(mem_rd_addr);
  assign bus_rdata   = bus_byte(bus_addr);

  int nvec = 0, nfail = 0, cyc = 0, t0 = 0;
  int wr_cnt = 0, first_d = -1, second_d = -1, last_d = -1, fall_d = -1;
  logic prev_busy = 0;
  logic [7:0] oam_m [160];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (oam_we) begin
      if (oam_addr < 8'd160) oam_m[oam_addr] = oam_wdata;
      if (wr_cnt == 0) first_d = cyc - t0;
      if (wr_cnt == 1) second_d = cyc - t0;
      last_d = cyc - t0;
      wr_cnt++;
    end
    if (prev_busy && !busy) fall_d = cyc - t0;
    prev_busy = busy;
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0; first_d = -1; second_d = -1; last_d = -1; fall_d = -1;
    for (int i = 0; i < 160; i++) oam_m[i] = 8'h00;
  endtask

  task automatic fire(input logic [7:0] page);
    @(posedge clk); #1;
    trig_valid = 1; trig_page = page;
    @(posedge clk); #1;
    trig_valid = 0;
    t0 = cyc;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic check_oam(input string req, input logic [7:0] page);
    int bad = 0;
    for (int i = 0; i < 160; i++)
      if (oam_m[i] !== src_byte({page, 8'(i)})) bad++;
    chk(req, bad, 0);
  endtask

  // entry: {blocked_while_busy, address}
  localparam logic [16:0] VEC [12] = '{
    {1'b1, 16'h0000}, {1'b1, 16'h7FFF}, {1'b1, 16'h8000}, {1'b1, 16'hA123},
    {1'b1, 16'hC000}, {1'b1, 16'hFE00}, {1'b1, 16'hFF00}, {1'b1, 16'hFF7F},
    {1'b0, 16'hFF80}, {1'b0, 16'hFFC0}, {1'b0, 16'hFFFE}, {1'b1, 16'hFFFF}};

  task automatic walk_table(input bit during_busy);
    for (int v = 0; v < 12; v++) begin
      logic blk;
      cpu_addr = VEC[v][15:0];
      cpu_wr = 1;
      blk = during_busy && VEC[v][16];
      #1;
      if (!during_busy) begin
        chk("R8 rdata", cpu_rdata, bus_byte(cpu_addr));
        chk("R8 wr", bus_wr, 1);
      end else if (blk) begin
        chk("R5 rdata", cpu_rdata, 8'hFF);
        chk("R6 wr", bus_wr, 0);
      end else begin
        chk("R7 rdata", cpu_rdata, bus_byte(cpu_addr));
        chk("R7 wr", bus_wr, 1);
      end
    end
    cpu_wr = 0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 oam_we", oam_we, 0);

    walk_table(0);

    // normal copy, timing and busy window
    clear_log();
    fire(8'h12);
    @(negedge clk);
    chk("R4 busy rise", busy, 1);
    repeat (20) @(posedge clk);
    #1;
    walk_table(1);
    wait_idle();
    chk("R3 first", first_d, 7);
    chk("R3 second", second_d, 11);
    chk("R3 last", last_d, 643);
    chk("R4 fall", fall_d, 644);
    chk("R2 count", wr_cnt, 160);
    check_oam("R2 data", 8'h12);
    cpu_addr = 16'h1234; #1;
    chk("R8 restored", cpu_rdata, bus_byte(16'h1234));

    // page above limit from idle
    clear_log();
    fire(8'hF2);
    @(negedge clk);
    chk("R1 ignored busy", busy, 0);
    repeat (20) @(posedge clk);
    #1;
    chk("R1 ignored writes", wr_cnt, 0);

    // highest legal page
    clear_log();
    fire(8'hF1);
    wait_idle();
    chk("R1 F1 count", wr_cnt, 160);
    check_oam("R1 F1 data", 8'hF1);

    // restart in a byte-move cycle
    clear_log();
    fire(8'h20);
    while (cyc < t0 + 27) begin @(posedge clk); #1; end
    trig_valid = 1; trig_page = 8'h40;
    #1;
    chk("R9 slot suppressed", oam_we, 0);
    @(posedge clk); #1;
    trig_valid = 0;
    t0 = cyc;
    wait_idle();
    chk("R9 count", wr_cnt, 165);
    chk("R9 fall", fall_d, 644);
    check_oam("R9 data", 8'h40);

    // ignored trigger during a copy
    clear_log();
    fire(8'h30);
    repeat (100) @(posedge clk);
    #1 trig_valid = 1; trig_page = 8'hF8;
    @(posedge clk); #1 trig_valid = 0;
    wait_idle();
    chk("R10 count", wr_cnt, 160);
    chk("R10 fall", fall_d, 644);
    check_oam("R10 data", 8'h30);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule